// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block guards a processor against runaway software. Out of hardware reset it sits disarmed and never times out. Software arms it by writing two key bytes to a write-only port: 0x1E first, then 0xE1 at once after it. Once armed, a 14-bit counter advances on every machine-cycle tick. Writing the same two-byte pair again restarts the count from zero. If software fails to do so in time, the counter overflows. The block then raises a reset request for a fixed number of clock cycles and falls back to the disarmed state.

There is no read path and no way to disarm the block, apart from hardware reset or its own overflow. Low-power states affect the count. In idle, a configuration bit chooses between counting on and pausing. In power-down the count freezes. After power-down ends, the count stays frozen until the wake-interrupt line (active low) has returned high. Another configuration bit suppresses the reset output while the overflow event is still reported.

The control state machine has five states. DISARMED goes to COUNTING when a key pair completes. COUNTING goes to ASLEEP while power-down is asserted, and to FIRING when the counter overflows. ASLEEP goes to WAKING when power-down drops. WAKING goes back to ASLEEP if power-down returns, and to COUNTING once the wake line is high. FIRING goes to DISARMED after the pulse length has elapsed. The key detector has two states. EXPECT_FIRST goes to EXPECT_SECOND on a write of 0x1E. EXPECT_SECOND always returns to EXPECT_FIRST on the next write, and it signals a completed pair only if that write was 0xE1.

Top module: `wdt_seq_guard`

## Requirements
- R1: After hardware reset `rst_out` and `ovf_evt` are 0 and the block is disarmed. With ticks present and no complete key pair, no overflow ever occurs.
- R2: Writing 0x1E and then 0xE1 on consecutive writes arms the block. With a tick on every clock, the overflow takes effect at the 16384th rising edge after the edge that samples 0xE1. Counting starts on the second edge, and the 16383rd counted tick overflows.
- R3: While armed, another 0x1E-then-0xE1 pair clears the counter. The next overflow again takes effect 16384 edges after the edge that samples 0xE1.
- R4: A write of any value other than 0x1E while waiting for the first key, or of any value other than 0xE1 right after 0x1E, cancels the partial pair. Such a write neither arms the block nor clears the counter. A second 0x1E right after 0x1E also cancels the pair.
- R5: On overflow `rst_out` goes high in the cycle after the overflowing edge and stays high for exactly 98 clock cycles. `ovf_evt` is high for that first cycle only.
- R6: After the pulse the block is disarmed. Key writes made during the pulse are ignored, and no further overflow occurs until a new key pair is written.
- R7: With `idle_hold`=0 ticks are counted while `idle`=1. With `idle_hold`=1 ticks are not counted while `idle`=1, and counting resumes when `idle` returns to 0.
- R8: While `pdown`=1 the counter is frozen. After `pdown` drops, the count stays frozen while `wake_n` is 0. Counting resumes on the edge after the edge that sees `wake_n`=1, and that edge itself is not counted.
- R9: With `rsto_mask`=1 an overflow still produces the one-cycle `ovf_evt`, but `rst_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| mc_tick | input | 1 | Machine-cycle tick, one clock wide |
| wr_en | input | 1 | Write strobe for the key port |
| wr_data | input | 8 | Key byte written |
| idle | input | 1 | Processor is in idle |
| idle_hold | input | 1 | 1 = pause counting during idle |
| pdown | input | 1 | Processor is in power-down |
| wake_n | input | 1 | Wake-interrupt line, active low |
| rsto_mask | input | 1 | 1 = suppress the reset output pulse |
| rst_out | output | 1 | Reset request pulse |
| ovf_evt | output | 1 | One-cycle overflow event |

## Verification
The counter is driven with a tick on every clock, and the first overflow edge is timed exactly. This timing shows apart a counter that wraps one tick early or late, and one that starts counting on the arming edge itself. The same measurement is repeated after a mid-run service, after corrupted key streams (a foreign byte, a doubled first key, a lone second key), across an idle window under both settings of `idle_hold`, and across a power-down followed by a late-rising wake line. Each of these shifts the expected edge by a known amount, so missed clears, spurious clears and wrong pause lengths all show up. The pulse is measured for width, for keys written while it is active, and with masking on.

// File: rtl/wdt_seq_pkg.sv
package wdt_seq_pkg;

    typedef enum logic [0:0] {
        KS_EXPECT_FIRST,
        KS_EXPECT_SECOND
    } key_state_t;

    typedef enum logic [2:0] {
        WS_DISARMED,
        WS_COUNTING,
        WS_ASLEEP,
        WS_WAKING,
        WS_FIRING
    } wdt_state_t;

endpackage

// File: rtl/wdt_key_unlock.sv
module wdt_key_unlock
    import wdt_seq_pkg::*;
#(
    parameter int               DATA_W     = 8,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h1E,
    parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              key_done
);

    key_state_t ks_q, ks_nxt;
    logic       hit;

    always_comb begin
        ks_nxt = ks_q;
        hit    = 1'b0;
        if (flush) begin
            ks_nxt = KS_EXPECT_FIRST;
        end else if (wr_en) begin
            unique case (ks_q)
                KS_EXPECT_FIRST: begin
                    if (wr_data == KEY_FIRST) ks_nxt = KS_EXPECT_SECOND;
                end
                KS_EXPECT_SECOND: begin
                    ks_nxt = KS_EXPECT_FIRST;
                    hit    = (wr_data == KEY_SECOND);
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ks_q     <= KS_EXPECT_FIRST;
            key_done <= 1'b0;
        end else begin
            ks_q     <= ks_nxt;
            key_done <= hit;
        end
    end

endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [CNT_W-1:0] count,
    output logic             at_last
);

    localparam logic [CNT_W-1:0] LAST_BEFORE_WRAP = {{(CNT_W-1){1'b1}}, 1'b0};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      count <= '0;
        else if (clr)    count <= '0;
        else if (adv)    count <= count + 1'b1;
    end

    assign at_last = (count == LAST_BEFORE_WRAP);

endmodule

// File: rtl/wdt_pulse_timer.sv
module wdt_pulse_timer #(
    parameter int PULSE_LEN = 98
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int TW = $clog2(PULSE_LEN + 1);
    localparam logic [TW-1:0] LAST = TW'(PULSE_LEN - 1);

    logic [TW-1:0] elapsed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    elapsed <= '0;
        else if (!run) elapsed <= '0;
        else           elapsed <= elapsed + 1'b1;
    end

    assign done = run && (elapsed == LAST);

endmodule

// File: rtl/wdt_seq_guard.sv
module wdt_seq_guard
    import wdt_seq_pkg::*;
#(
    parameter int                CNT_W      = 14,
    parameter int                PULSE_LEN  = 98,
    parameter int                DATA_W     = 8,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h1E,
    parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              idle,
    input  logic              idle_hold,
    input  logic              pdown,
    input  logic              wake_n,
    input  logic              rsto_mask,
    output logic              rst_out,
    output logic              ovf_evt
);

    wdt_state_t       state, state_nxt;
    logic             key_done;
    logic             counting;
    logic             fire;
    logic             pulse_done;
    logic             at_last;
    logic [CNT_W-1:0] count;

    wdt_key_unlock #(
        .DATA_W    (DATA_W),
        .KEY_FIRST (KEY_FIRST),
        .KEY_SECOND(KEY_SECOND)
    ) u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (state == WS_FIRING),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .key_done(key_done)
    );

    // A counted tick needs the running state, no pending service and no idle pause
    assign counting = (state == WS_COUNTING) && !pdown && mc_tick
                      && !(idle && idle_hold) && !key_done;
    assign fire     = counting && at_last;

    wdt_tick_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (key_done || fire),
        .adv    (counting && !at_last),
        .count  (count),
        .at_last(at_last)
    );

    wdt_pulse_timer #(
        .PULSE_LEN(PULSE_LEN)
    ) u_pulse (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state == WS_FIRING),
        .done (pulse_done)
    );

    always_comb begin
        state_nxt = state;
        unique case (state)
            WS_DISARMED: if (key_done) state_nxt = WS_COUNTING;
            WS_COUNTING: begin
                if (pdown)     state_nxt = WS_ASLEEP;
                else if (fire) state_nxt = WS_FIRING;
            end
            WS_ASLEEP:   if (!pdown) state_nxt = WS_WAKING;
            WS_WAKING: begin
                if (pdown)       state_nxt = WS_ASLEEP;
                else if (wake_n) state_nxt = WS_COUNTING;
            end
            WS_FIRING:   if (pulse_done) state_nxt = WS_DISARMED;
            default:     state_nxt = WS_DISARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= WS_DISARMED;
            ovf_evt <= 1'b0;
        end else begin
            state   <= state_nxt;
            ovf_evt <= fire;
        end
    end

    always_comb begin
        rst_out = (state == WS_FIRING) && !rsto_mask;
    end

endmodule

// File: rtl/wdt_seq_guard_chk.sv
module wdt_seq_guard_chk
    import wdt_seq_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input wdt_state_t       state,
    input logic [CNT_W-1:0] count,
    input logic             key_done,
    input logic             idle,
    input logic             idle_hold,
    input logic             pdown,
    input logic             rsto_mask,
    input logic             rst_out,
    input logic             ovf_evt
);

    AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WS_DISARMED) |=> !ovf_evt); // R1

    AST_EVENT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> !ovf_evt); // R5

    AST_PULSE_WITH_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !rsto_mask) |-> rst_out); // R5

    AST_IDLE_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WS_COUNTING && idle && idle_hold && !key_done && !pdown) |=> $stable(count)); // R7

    AST_SLEEP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WS_ASLEEP && !key_done) |=> $stable(count)); // R8

    AST_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        rsto_mask |-> !rst_out); // R9

endmodule

bind wdt_seq_guard wdt_seq_guard_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .count    (count),
    .key_done (key_done),
    .idle     (idle),
    .idle_hold(idle_hold),
    .pdown    (pdown),
    .rsto_mask(rsto_mask),
    .rst_out  (rst_out),
    .ovf_evt  (ovf_evt)
);

// File: tb/sim_wdt_seq_guard.sv
module sim_wdt_seq_guard;

    localparam int FULL_GAP = 16384;
    localparam int PULSE    = 98;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_tick = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       idle = 1'b0;
    logic       idle_hold = 1'b0;
    logic       pdown = 1'b0;
    logic       wake_n = 1'b1;
    logic       rsto_mask = 1'b0;
    logic       rst_out;
    logic       ovf_evt;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    wdt_seq_guard u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .mc_tick  (mc_tick),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .idle     (idle),
        .idle_hold(idle_hold),
        .pdown    (pdown),
        .wake_n   (wake_n),
        .rsto_mask(rsto_mask),
        .rst_out  (rst_out),
        .ovf_evt  (ovf_evt)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; idle = 1'b0; idle_hold = 1'b0;
        pdown = 1'b0; wake_n = 1'b1; rsto_mask = 1'b0; mc_tick = 1'b1;
        repeat (3) step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic write_byte(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b;
        step();
        wr_en = 1'b0;
    endtask

    task automatic write_key();
        write_byte(8'h1E);
        write_byte(8'hE1);
    endtask

    task automatic expect_fire(input int gap, input bit masked, input string req);
        bit early = 1'b0;
        for (int i = 0; i < gap - 1; i++) begin
            step();
            if (rst_out || ovf_evt) early = 1'b1;
        end
        check(!early, req, "quiet before overflow edge", int'(early), 0);
        step();
        check(ovf_evt == 1'b1, req, "ovf_evt at overflow", int'(ovf_evt), 1);
        check(rst_out == !masked, req, "rst_out at overflow", int'(rst_out), int'(!masked));
    endtask

    task automatic quiet_window(input int n, input string req);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            step();
            if (rst_out || ovf_evt) seen = 1'b1;
        end
        check(!seen, req, "no overflow while disarmed", int'(seen), 0);
    endtask

    // R1: reset state and broken sequences never arm
    task automatic t_reset_and_locked();
        do_reset();
        check(rst_out == 1'b0, "R1", "rst_out after reset", int'(rst_out), 0);
        check(ovf_evt == 1'b0, "R1", "ovf_evt after reset", int'(ovf_evt), 0);
        write_byte(8'hE1); write_byte(8'h1E); write_byte(8'h1E); write_byte(8'hE1);
        write_byte(8'h1E); write_byte(8'h55); write_byte(8'hE1);
        quiet_window(FULL_GAP + 600, "R4");
    endtask

    // R2, R5, R6: arm, overflow timing, pulse width, disarmed afterwards
    task automatic t_arm_and_pulse();
        bit dropped = 1'b0;
        do_reset();
        write_key();
        expect_fire(FULL_GAP, 1'b0, "R2");
        step();
        check(ovf_evt == 1'b0, "R5", "ovf_evt single cycle", int'(ovf_evt), 0);
        write_byte(8'h1E);
        write_byte(8'hE1);
        for (int i = 0; i < PULSE - 4; i++) begin
            if (!rst_out) dropped = 1'b1;
            step();
        end
        if (!rst_out) dropped = 1'b1;
        check(!dropped, "R5", "rst_out held through pulse", int'(dropped), 0);
        step();
        check(rst_out == 1'b0, "R5", "rst_out after 98 cycles", int'(rst_out), 0);
        quiet_window(FULL_GAP + 600, "R6");
    endtask

    // R3: service mid-run restarts the count
    task automatic t_service();
        do_reset();
        write_key();
        repeat (5000) step();
        write_key();
        expect_fire(FULL_GAP, 1'b0, "R3");
    endtask

    // R4: foreign and misordered writes while armed do not clear
    task automatic t_bad_writes_armed();
        do_reset();
        write_key();
        repeat (3000) step();
        write_byte(8'h55); write_byte(8'h1E); write_byte(8'h1E); write_byte(8'hE1);
        write_byte(8'hE1); write_byte(8'h1E); write_byte(8'h00); write_byte(8'hE1);
        expect_fire(FULL_GAP - 3008, 1'b0, "R4");
    endtask

    // R7: idle with counting on, then idle with pause
    task automatic t_idle();
        do_reset();
        idle = 1'b1; idle_hold = 1'b0;
        write_key();
        expect_fire(FULL_GAP, 1'b0, "R7");
        do_reset();
        idle_hold = 1'b1;
        write_key();
        repeat (1000) step();
        idle = 1'b1;
        repeat (5000) step();
        idle = 1'b0;
        expect_fire(FULL_GAP + 5000 - 6000, 1'b0, "R7");
    endtask

    // R8: power-down freeze, then held until the wake line rises
    task automatic t_powerdown();
        do_reset();
        write_key();
        repeat (1000) step();
        pdown = 1'b1; wake_n = 1'b0;
        repeat (3000) step();
        pdown = 1'b0;
        repeat (2000) step();
        wake_n = 1'b1;
        expect_fire(FULL_GAP + 5001 - 6000, 1'b0, "R8");
    endtask

    // R9: masked output still reports the event
    task automatic t_mask();
        do_reset();
        rsto_mask = 1'b1;
        write_key();
        expect_fire(FULL_GAP, 1'b1, "R9");
        step();
        check(rst_out == 1'b0, "R9", "rst_out stays low when masked", int'(rst_out), 0);
    endtask

    initial begin
        t_reset_and_locked();
        t_arm_and_pulse();
        t_service();
        t_bad_writes_armed();
        t_idle();
        t_powerdown();
        t_mask();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule